// File: doc/BRIEF.md
# Translation Buffer with Write-Permission Checking

This block is a small fully associative translation buffer that sits between a processor's address generator and its cache. Each lookup gives a 32-bit virtual address and a read/write flag. The upper 20 bits are the virtual page number; they are compared against every stored slot. A slot matches only when its valid bit is set and its stored page number equals the requested one. On a match, the 18-bit physical page number and the untranslated 12-bit page offset form a 30-bit physical address. A write to a slot whose write permission is clear raises a write-protection exception and delivers no address. When nothing matches, the block raises a miss exception so that software can walk the page table itself and refill a slot.

Software refills slots through a separate port. It either names a slot index, or asks the block to pick one with a round-robin pointer. A flush input invalidates all sixteen slots in one cycle. If two valid slots hold the same page number, the lowest-numbered one supplies the translation and a multi-hit flag is raised with the response.

The result of each lookup is held in a four-state response register: `ST_IDLE` (no lookup last cycle), `ST_HIT` (address delivered), `ST_MISS` (miss exception) and `ST_PROT` (write-protection exception). Every cycle the next state is chosen as follows:
- no request goes to `ST_IDLE`;
- a request with no match goes to `ST_MISS`;
- a matching write without permission goes to `ST_PROT`;
- any other matching request goes to `ST_HIT`.

Any state can move to any other state on the next clock.

Top module: `tlb_xlate`

## Requirements
- R1: After reset all response outputs are 0, all slots are invalid, and the round-robin pointer is 0.
- R2: A lookup that matches a valid slot, and is either a read or a write to a writable slot, sets `rsp_ok` one cycle later. `rsp_paddr` is then {slot physical page number, vaddr[11:0]}.
- R3: A lookup whose vaddr[31:12] matches no valid slot sets `rsp_miss` one cycle later, and `rsp_paddr` is 0.
- R4: A write lookup that matches a slot whose write bit is 0 sets `rsp_wprot` with `rsp_paddr` 0. A read lookup of the same slot sets `rsp_ok`.
- R5: A write lookup that matches a slot whose write bit is 1 sets `rsp_ok` with the translated address.
- R6: A refill is written at the clock edge where `rf_en` is 1. A lookup sampled at that same edge sees the slot contents from before the refill.
- R7: With `rf_auto` = 1 the refill goes to the slot named by the round-robin pointer, which then advances by one and wraps from 15 to 0. With `rf_auto` = 0 the slot is `rf_idx`, and the pointer does not move.
- R8: `flush` clears every valid bit at the next edge. A refill requested in the same cycle as a flush is dropped, and the pointer does not move.
- R9: When several valid slots match, the lowest-numbered slot supplies the address, and `rsp_multi` is 1 alongside the response. `rsp_multi` is 0 when exactly one slot matches.
- R10: Exactly one of `rsp_ok`, `rsp_miss`, `rsp_wprot` is 1 in the cycle after a lookup request. All of them, and `rsp_valid`, are 0 in the cycle after a cycle with no request.
- R11: A refill with `rf_valid` = 0 leaves the slot invalid, so later lookups of its page number miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_req | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | 32 | Virtual address to translate |
| flush | input | 1 | Invalidate every slot |
| rf_en | input | 1 | Refill strobe |
| rf_auto | input | 1 | 1: slot chosen by round-robin pointer; 0: slot given by rf_idx |
| rf_idx | input | 4 | Slot index for an indexed refill |
| rf_vpn | input | 20 | Virtual page number to store |
| rf_ppn | input | 18 | Physical page number to store |
| rf_valid | input | 1 | Valid bit to store |
| rf_wr | input | 1 | Write-permission bit to store |
| rsp_valid | output | 1 | A lookup result is present |
| rsp_ok | output | 1 | Translation delivered |
| rsp_paddr | output | 30 | Physical address, 0 unless rsp_ok |
| rsp_miss | output | 1 | Miss exception |
| rsp_wprot | output | 1 | Write-protection exception |
| rsp_multi | output | 1 | More than one valid slot matched |

## Verification
The bench builds the block with its default parameters: 16 slots, a 20-bit page number, an 18-bit frame number and a 12-bit offset. With 16 slots, a sequence of seventeen automatic refills is short enough to show the pointer's exact order and its wrap back to slot 0. An indexed overwrite between those refills shows which slot each one landed in. The bench also stores the same page number in two slots to exercise the priority choice and the multi-hit flag. It drives a flush and a refill in the same cycle to confirm that the flush wins.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Response register states: one per lookup outcome
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2,
        ST_PROT = 2'd3
    } tlb_state_e;

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PPN_W = 18,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      flush,
    input  logic                      rf_en,
    input  logic                      rf_auto,
    input  logic [IDX_W-1:0]          rf_idx,
    input  logic [VPN_W-1:0]          rf_vpn,
    input  logic [PPN_W-1:0]          rf_ppn,
    input  logic                      rf_valid,
    input  logic                      rf_wr,
    output logic [N-1:0]              slot_vld,
    output logic [N-1:0]              slot_wen,
    output logic [N-1:0][VPN_W-1:0]   slot_vpn,
    output logic [N-1:0][PPN_W-1:0]   slot_ppn
);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] tgt;
    logic             do_fill;

    // Flush has priority; a refill in the same cycle is dropped
    assign do_fill = rf_en && !flush;
    assign tgt     = rf_auto ? rr_ptr : rf_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (do_fill && rf_auto) begin
            rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                slot_vld[g] <= 1'b0;
            end else if (do_fill && tgt == IDX_W'(g)) begin
                slot_vld[g] <= rf_valid;
            end
        end

        always_ff @(posedge clk) begin
            if (do_fill && tgt == IDX_W'(g)) begin
                slot_wen[g] <= rf_wr;
                slot_vpn[g] <= rf_vpn;
                slot_ppn[g] <= rf_ppn;
            end
        end
    end

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PPN_W = 18
) (
    input  logic [VPN_W-1:0]          req_vpn,
    input  logic [N-1:0]              slot_vld,
    input  logic [N-1:0]              slot_wen,
    input  logic [N-1:0][VPN_W-1:0]   slot_vpn,
    input  logic [N-1:0][PPN_W-1:0]   slot_ppn,
    output logic                      hit,
    output logic                      multi,
    output logic [PPN_W-1:0]          sel_ppn,
    output logic                      sel_wen
);

    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = slot_vld[g] && (slot_vpn[g] == req_vpn);
    end

    assign hit   = |match;
    // More than one bit set: clearing the lowest set bit leaves something
    assign multi = |(match & (match - 1'b1));

    // Scan from the top so the lowest matching slot is the last written
    always_comb begin
        sel_ppn = '0;
        sel_wen = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel_ppn = slot_ppn[i];
                sel_wen = slot_wen[i];
            end
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
    parameter int N_SLOTS = 16,
    parameter int VA_W    = 32,
    parameter int OFS_W   = 12,
    parameter int PPN_W   = 18,
    localparam int VPN_W  = VA_W - OFS_W,
    localparam int PA_W   = PPN_W + OFS_W,
    localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic              lk_write,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              flush,
    input  logic              rf_en,
    input  logic              rf_auto,
    input  logic [IDX_W-1:0]  rf_idx,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [PPN_W-1:0]  rf_ppn,
    input  logic              rf_valid,
    input  logic              rf_wr,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_miss,
    output logic              rsp_wprot,
    output logic              rsp_multi
);
    import tlb_pkg::*;

    logic [N_SLOTS-1:0]             slot_vld;
    logic [N_SLOTS-1:0]             slot_wen;
    logic [N_SLOTS-1:0][VPN_W-1:0]  slot_vpn;
    logic [N_SLOTS-1:0][PPN_W-1:0]  slot_ppn;
    logic                           hit;
    logic                           multi;
    logic [PPN_W-1:0]               sel_ppn;
    logic                           sel_wen;

    tlb_state_e       state_q, state_d;
    logic [PA_W-1:0]  paddr_q;
    logic             multi_q;

    tlb_entry_array #(
        .N     (N_SLOTS),
        .VPN_W (VPN_W),
        .PPN_W (PPN_W)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .rf_en    (rf_en),
        .rf_auto  (rf_auto),
        .rf_idx   (rf_idx),
        .rf_vpn   (rf_vpn),
        .rf_ppn   (rf_ppn),
        .rf_valid (rf_valid),
        .rf_wr    (rf_wr),
        .slot_vld (slot_vld),
        .slot_wen (slot_wen),
        .slot_vpn (slot_vpn),
        .slot_ppn (slot_ppn)
    );

    tlb_match #(
        .N     (N_SLOTS),
        .VPN_W (VPN_W),
        .PPN_W (PPN_W)
    ) u_match (
        .req_vpn  (lk_vaddr[VA_W-1:OFS_W]),
        .slot_vld (slot_vld),
        .slot_wen (slot_wen),
        .slot_vpn (slot_vpn),
        .slot_ppn (slot_ppn),
        .hit      (hit),
        .multi    (multi),
        .sel_ppn  (sel_ppn),
        .sel_wen  (sel_wen)
    );

    // Next-state selection from the current lookup
    always_comb begin
        if (!lk_req) begin
            state_d = ST_IDLE;
        end else if (!hit) begin
            state_d = ST_MISS;
        end else if (lk_write && !sel_wen) begin
            state_d = ST_PROT;
        end else begin
            state_d = ST_HIT;
        end
    end

    // State register with the captured address and multi-hit flag
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            paddr_q <= '0;
            multi_q <= 1'b0;
        end else begin
            state_q <= state_d;
            paddr_q <= (state_d == ST_HIT) ? {sel_ppn, lk_vaddr[OFS_W-1:0]} : '0;
            multi_q <= lk_req && multi;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_ok    = 1'b0;
        rsp_miss  = 1'b0;
        rsp_wprot = 1'b0;
        rsp_paddr = '0;
        rsp_multi = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HIT: begin
                rsp_valid = 1'b1;
                rsp_ok    = 1'b1;
                rsp_paddr = paddr_q;
                rsp_multi = multi_q;
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
                rsp_miss  = 1'b1;
            end
            ST_PROT: begin
                rsp_valid = 1'b1;
                rsp_wprot = 1'b1;
                rsp_multi = multi_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int VA_W  = 32,
    parameter int OFS_W = 12,
    parameter int PA_W  = 30
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_req,
    input logic             lk_write,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             flush,
    input logic             rsp_valid,
    input logic             rsp_ok,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_miss,
    input logic             rsp_wprot
);

    a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_ok, rsp_miss, rsp_wprot}) == 1));

    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_ok || rsp_miss || rsp_wprot));

    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_valid);

    a_r3_no_addr: assert property (@(posedge clk) disable iff (rst)
        !rsp_ok |-> (rsp_paddr == '0));

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> (rsp_ok -> (rsp_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0]))));

    a_r4_prot_only_write: assert property (@(posedge clk) disable iff (rst)
        lk_req && !lk_write |=> !rsp_wprot);

    a_r8_flush_misses: assert property (@(posedge clk) disable iff (rst)
        flush ##1 lk_req |=> rsp_miss);

endmodule

bind tlb_xlate tlb_xlate_chk #(
    .VA_W  (VA_W),
    .OFS_W (OFS_W),
    .PA_W  (PA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_req    (lk_req),
    .lk_write  (lk_write),
    .lk_vaddr  (lk_vaddr),
    .flush     (flush),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_paddr (rsp_paddr),
    .rsp_miss  (rsp_miss),
    .rsp_wprot (rsp_wprot)
);

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;

    localparam int K_OK   = 0;
    localparam int K_MISS = 1;
    localparam int K_PROT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic        lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        flush = 1'b0;
    logic        rf_en = 1'b0;
    logic        rf_auto = 1'b0;
    logic [3:0]  rf_idx = '0;
    logic [19:0] rf_vpn = '0;
    logic [17:0] rf_ppn = '0;
    logic        rf_valid = 1'b0;
    logic        rf_wr = 1'b0;
    logic        rsp_valid, rsp_ok, rsp_miss, rsp_wprot, rsp_multi;
    logic [29:0] rsp_paddr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tlb_xlate u0 (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_write(lk_write),
        .lk_vaddr(lk_vaddr), .flush(flush), .rf_en(rf_en), .rf_auto(rf_auto),
        .rf_idx(rf_idx), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_valid(rf_valid),
        .rf_wr(rf_wr), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_paddr(rsp_paddr), .rsp_miss(rsp_miss), .rsp_wprot(rsp_wprot),
        .rsp_multi(rsp_multi)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // {valid, ok, miss, wprot, multi, paddr}
    task automatic expect_rsp(string tag, int kind, logic [29:0] pa, logic mh);
        logic [34:0] got, exp;
        got = {rsp_valid, rsp_ok, rsp_miss, rsp_wprot, rsp_multi, rsp_paddr};
        exp = {1'b1, kind == K_OK, kind == K_MISS, kind == K_PROT, mh,
               (kind == K_OK) ? pa : 30'd0};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got v/ok/miss/prot/multi/pa=%b %b %b %b %b %h, expected %b %b %b %b %b %h",
                     tag, got[34], got[33], got[32], got[31], got[30], got[29:0],
                     exp[34], exp[33], exp[32], exp[31], exp[30], exp[29:0]);
        end
    endtask

    task automatic expect_idle(string tag);
        logic [34:0] got;
        got = {rsp_valid, rsp_ok, rsp_miss, rsp_wprot, rsp_multi, rsp_paddr};
        checks++;
        if (got !== 35'd0) begin
            errors++;
            $display("FAIL %s: got %h, expected 0", tag, got);
        end
    endtask

    task automatic refill(logic auto, logic [3:0] idx, logic [19:0] vpn,
                          logic [17:0] ppn, logic v, logic w);
        rf_en = 1'b1; rf_auto = auto; rf_idx = idx; rf_vpn = vpn;
        rf_ppn = ppn; rf_valid = v; rf_wr = w;
        tick();
        rf_en = 1'b0; rf_auto = 1'b0;
    endtask

    task automatic lookup(logic [31:0] va, logic wr);
        lk_req = 1'b1; lk_vaddr = va; lk_write = wr;
        tick();
        lk_req = 1'b0; lk_write = 1'b0;
    endtask

    task automatic t_reset();
        expect_idle("R1 outputs after reset");
        lookup(32'h0000_0000, 1'b0);
        expect_rsp("R1 empty buffer misses", K_MISS, '0, 1'b0);
        tick();
        expect_idle("R10 idle cycle after lookup");
    endtask

    task automatic t_round_robin();
        for (int i = 0; i < 16; i++) refill(1'b1, 4'd9, 20'h00100 + 20'(i), 18'(i + 1), 1'b1, 1'b1);
        lookup(32'h0010_FABC, 1'b0);
        expect_rsp("R7 last auto slot holds page", K_OK, {18'd16, 12'hABC}, 1'b0);
        refill(1'b0, 4'd4, 20'hFFFFF, 18'h3FFFF, 1'b1, 1'b1);
        lookup(32'h0010_4000, 1'b0);
        expect_rsp("R7 fifth auto refill went to slot 4", K_MISS, '0, 1'b0);
        refill(1'b1, 4'd9, 20'h00200, 18'h00222, 1'b1, 1'b1);
        lookup(32'h0010_0000, 1'b0);
        expect_rsp("R7 pointer wrapped to slot 0", K_MISS, '0, 1'b0);
        lookup(32'h0010_1123, 1'b0);
        expect_rsp("R7 slot 1 untouched", K_OK, {18'd2, 12'h123}, 1'b0);
        lookup(32'h0020_0001, 1'b1);
        expect_rsp("R7 wrapped refill usable", K_OK, {18'h00222, 12'h001}, 1'b0);
    endtask

    task automatic t_flush();
        flush = 1'b1;
        refill(1'b0, 4'd6, 20'h0AAAA, 18'h0BBBB, 1'b1, 1'b1);
        flush = 1'b0;
        lookup(32'h0010_1000, 1'b0);
        expect_rsp("R8 flush clears slots", K_MISS, '0, 1'b0);
        lookup(32'h0AAA_A000, 1'b0);
        expect_rsp("R8 refill with flush dropped", K_MISS, '0, 1'b0);
    endtask

    task automatic t_hit();
        refill(1'b0, 4'd3, 20'h12345, 18'h2ABCD, 1'b1, 1'b1);
        lookup(32'h1234_5678, 1'b0);
        expect_rsp("R2 read hit translates", K_OK, {18'h2ABCD, 12'h678}, 1'b0);
        lookup(32'h1234_5FFF, 1'b1);
        expect_rsp("R5 write to writable slot", K_OK, {18'h2ABCD, 12'hFFF}, 1'b0);
    endtask

    task automatic t_miss();
        lookup(32'h5432_1000, 1'b1);
        expect_rsp("R3 unmatched page misses", K_MISS, '0, 1'b0);
    endtask

    task automatic t_wprot();
        refill(1'b0, 4'd5, 20'h00ABC, 18'h00111, 1'b1, 1'b0);
        lookup(32'h00AB_C010, 1'b1);
        expect_rsp("R4 write to read-only slot", K_PROT, '0, 1'b0);
        lookup(32'h00AB_C010, 1'b0);
        expect_rsp("R4 read of read-only slot", K_OK, {18'h00111, 12'h010}, 1'b0);
    endtask

    task automatic t_same_cycle();
        rf_en = 1'b1; rf_idx = 4'd7; rf_vpn = 20'h0F0F0; rf_ppn = 18'h01234;
        rf_valid = 1'b1; rf_wr = 1'b1;
        lookup(32'h0F0F_0044, 1'b0);
        rf_en = 1'b0;
        expect_rsp("R6 lookup sees pre-refill contents", K_MISS, '0, 1'b0);
        lookup(32'h0F0F_0044, 1'b0);
        expect_rsp("R6 refill visible next cycle", K_OK, {18'h01234, 12'h044}, 1'b0);
    endtask

    task automatic t_invalidate();
        refill(1'b0, 4'd3, 20'h12345, 18'h2ABCD, 1'b0, 1'b1);
        lookup(32'h1234_5678, 1'b0);
        expect_rsp("R11 invalid refill does not match", K_MISS, '0, 1'b0);
    endtask

    task automatic t_multi();
        refill(1'b0, 4'd9, 20'h00777, 18'h00009, 1'b1, 1'b1);
        refill(1'b0, 4'd2, 20'h00777, 18'h00002, 1'b1, 1'b1);
        lookup(32'h0077_7ABC, 1'b0);
        expect_rsp("R9 lowest slot wins with multi flag", K_OK, {18'h00002, 12'hABC}, 1'b1);
        tick();
        expect_idle("R10 idle after multi-hit");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        t_reset();
        t_round_robin();
        t_flush();
        t_hit();
        t_miss();
        t_wprot();
        t_same_cycle();
        t_invalidate();
        t_multi();
        tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule